// File: doc/BRIEF.md
# Multi-channel edge-event FIFO writer

This block stamps every level change on four digitised detector lines while a sampling window is open, and writes each event to an external FIFO. One written word holds the stamp (the number of clock edges since the window opened) in its upper bits and a per-channel source mask in its lower bits. The write strobe is active low. Its width comes from XOR-ing each line with a copy of itself held back by a short flop chain. The strobe is re-registered on the falling clock edge, so the FIFO sees stable data well before the strobe's rising edge.

Changes on several channels at the same edge, or close together in time, produce one write. Every channel that took part is flagged in the mask. Changes seen while the window is closed start no write. The inputs are taken to be synchronous to the clock already. Each channel holds its level for at least three clocks between changes.

Top module: `evt_fifo_writer`

## Requirements
- R1: While reset is high and just after it, `fifo_wr_n` is 1 and `fifo_data` is 0.
- R2: A single rising or falling change on one channel inside the window gives exactly one write. `fifo_wr_n` is low for exactly DLY (3) clock periods.
- R3: The stamp sits in `fifo_data[CW+NCH-1:NCH]`. It equals the number of clock edges from the edge that first sees `win` high to the edge that first sees the change, taken modulo 2^CW. Reopening the window restarts it from 0.
- R4: Bit i of `fifo_data[NCH-1:0]` is 1 exactly when channel i contributed to the write. Changes on any set of channels at the same edge give one write of width DLY, with all of those bits set.
- R5: A change on another channel that arrives at most DLY edges after the latest contributing change joins the current write. The stamp stays that of the first change. The low time extends to DLY plus the offset in edges.
- R6: Changes spaced DLY+1 edges or more apart give separate writes, each with its own stamp and a width of DLY.
- R7: A change seen while `win` is low starts no write. A write started inside the window completes with full width even if `win` falls during it.
- R8: `fifo_data` does not change between the last contributing change and the rising edge of `fifo_wr_n`. The strobe changes only on falling clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_in | input | NCH | Digitised detector lines, one bit per channel |
| win | input | 1 | Sampling window, high while events are to be recorded |
| fifo_data | output | CW+NCH | Word to the FIFO: stamp above, source mask below |
| fifo_wr_n | output | 1 | Active-low FIFO write strobe |

## Verification
The hardest case to reach is the border between merging and splitting. A second channel changes exactly DLY or DLY+1 edges after the first, where the two request windows just touch or just miss. The bench sweeps the second change's offset from 1 to 5 edges. At each offset it checks how many writes appear, their masks, their stamps and their low times. It also closes the window one edge into a pulse to show the write still completes, and it runs the stamp past its wrap point.

// File: rtl/evt_fifo_pkg.sv
package evt_fifo_pkg;
  parameter int unsigned DEF_NCH = 4;
  parameter int unsigned DEF_CW  = 16;
  parameter int unsigned DEF_DLY = 3;

  function automatic int unsigned word_width(int unsigned nch, int unsigned cw);
    return nch + cw;
  endfunction
endpackage

// File: rtl/evt_edge_extract.sv
module evt_edge_extract #(
  parameter int unsigned DLY = evt_fifo_pkg::DEF_DLY
) (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  input  logic win,
  output logic start,
  output logic req
);
  logic [DLY-1:0] dly;
  logic           armed;
  logic           chg_now;
  logic           stretch;

  always_ff @(posedge clk) begin
    if (rst) dly <= '0;
    else     dly <= {dly[DLY-2:0], sig};
  end

  // first cycle of a change, and the DLY-wide stretched version
  assign chg_now = sig ^ dly[0];
  assign stretch = sig ^ dly[DLY-1];

  // a stretched pulse only counts if its change was seen inside the window
  always_ff @(posedge clk) begin
    if (rst)          armed <= 1'b0;
    else if (chg_now) armed <= win;
  end

  assign start = chg_now & win;
  assign req   = stretch & (chg_now ? win : armed);
endmodule

// File: rtl/evt_stamp_counter.sv
module evt_stamp_counter #(
  parameter int unsigned CW = evt_fifo_pkg::DEF_CW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win,
  output logic [CW-1:0] stamp
);
  logic          win_q;
  logic [CW-1:0] cnt;

  assign stamp = (win & ~win_q) ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= 1'b0;
      cnt   <= '0;
    end else begin
      win_q <= win;
      cnt   <= stamp + CW'(1);
    end
  end
endmodule

// File: rtl/evt_merge_writer.sv
module evt_merge_writer #(
  parameter int unsigned NCH = evt_fifo_pkg::DEF_NCH,
  parameter int unsigned CW  = evt_fifo_pkg::DEF_CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    start,
  input  logic [NCH-1:0]    req,
  input  logic [CW-1:0]     stamp,
  output logic [CW+NCH-1:0] data,
  output logic              wr_n
);
  logic act;
  logic act_q;

  assign act = |req;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      data  <= '0;
    end else begin
      act_q <= act;
      if (act && !act_q)
        data <= {stamp, start};
      else if (act)
        data[NCH-1:0] <= data[NCH-1:0] | start;
    end
  end

  // strobe re-timed onto the falling edge
  always_ff @(negedge clk) begin
    if (rst) wr_n <= 1'b1;
    else     wr_n <= ~act_q;
  end
endmodule

// File: rtl/evt_fifo_writer.sv
module evt_fifo_writer #(
  parameter int unsigned NCH = evt_fifo_pkg::DEF_NCH,
  parameter int unsigned CW  = evt_fifo_pkg::DEF_CW,
  parameter int unsigned DLY = evt_fifo_pkg::DEF_DLY
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    ch_in,
  input  logic              win,
  output logic [CW+NCH-1:0] fifo_data,
  output logic              fifo_wr_n
);
  localparam int unsigned DW = evt_fifo_pkg::word_width(NCH, CW);

  logic [NCH-1:0] ch_start;
  logic [NCH-1:0] ch_req;
  logic [CW-1:0]  cur_stamp;
  logic [DW-1:0]  word;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    evt_edge_extract #(.DLY(DLY)) u_edge (
      .clk   (clk),
      .rst   (rst),
      .sig   (ch_in[i]),
      .win   (win),
      .start (ch_start[i]),
      .req   (ch_req[i])
    );
  end

  evt_stamp_counter #(.CW(CW)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .win   (win),
    .stamp (cur_stamp)
  );

  evt_merge_writer #(.NCH(NCH), .CW(CW)) u_merge (
    .clk   (clk),
    .rst   (rst),
    .start (ch_start),
    .req   (ch_req),
    .stamp (cur_stamp),
    .data  (word),
    .wr_n  (fifo_wr_n)
  );

  assign fifo_data = word;
endmodule

// File: rtl/evt_fifo_writer_chk.sv
module evt_fifo_writer_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned DLY = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              win,
  input logic [CW+NCH-1:0] fifo_data,
  input logic              fifo_wr_n
);
  logic [7:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)                  low_cnt <= '0;
    else if (!fifo_wr_n) begin
      if (low_cnt != 8'hFF)   low_cnt <= low_cnt + 8'd1;
    end else                  low_cnt <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_wr_n) |-> (low_cnt >= 8'(DLY))); // R2

  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_wr_n) |-> (fifo_data[NCH-1:0] != '0)); // R4

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_wr_n) |-> $stable(fifo_data)); // R8

  AST_WIN_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_wr_n) |-> $past(win)); // R7
endmodule

bind evt_fifo_writer evt_fifo_writer_chk #(.NCH(NCH), .CW(CW), .DLY(DLY)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .win       (win),
  .fifo_data (fifo_data),
  .fifo_wr_n (fifo_wr_n)
);

// File: tb/evt_fifo_writer_bench.sv
module evt_fifo_writer_bench;
  localparam int CLK_PER = 10;
  localparam int NCH = 4;
  localparam int CW  = 8;
  localparam int DLY = 3;
  localparam int DW  = CW + NCH;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           win = 1'b0;
  logic [NCH-1:0] ch  = '0;
  logic [DW-1:0]  fifo_data;
  logic           fifo_wr_n;

  evt_fifo_writer #(.NCH(NCH), .CW(CW), .DLY(DLY)) u_evt_fifo_writer (
    .clk       (clk),
    .rst       (rst),
    .ch_in     (ch),
    .win       (win),
    .fifo_data (fifo_data),
    .fifo_wr_n (fifo_wr_n)
  );

  always #(CLK_PER/2) clk = ~clk;

  int checks = 0;
  int errs   = 0;
  int slot   = 0;
  int sw     = 0;
  logic [DW-1:0] got_d [0:63];
  int            got_w [0:63];
  int            got_n = 0;
  int            lowc  = 0;
  logic          prev  = 1'b1;

  // write monitor: samples between the falling edge and the next rising edge
  initial forever begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (!fifo_wr_n) lowc++;
      else begin
        if (!prev && got_n < 64) begin
          got_d[got_n] = fifo_data;
          got_w[got_n] = lowc;
          got_n++;
        end
        lowc = 0;
      end
      prev = fifo_wr_n;
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
      slot++;
    end
  endtask

  task automatic chk(input string r, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errs++;
      $display("FAIL %s got=%0d exp=%0d", r, got, exp);
    end
  endtask

  task automatic chk_write(input string r, input int idx, input int m, input int st, input int w);
    chk({r, " mask"},  int'(got_d[idx][NCH-1:0]), m);
    chk({r, " stamp"}, int'(got_d[idx][DW-1:NCH]), st % (1 << CW));
    chk({r, " width"}, got_w[idx], w);
  endtask

  initial begin
    int se;
    step(3);
    chk("R1 wr_n in reset", int'(fifo_wr_n), 1);
    chk("R1 data in reset", int'(fifo_data), 0);
    rst = 1'b0;
    step(2);
    chk("R1 wr_n after reset", int'(fifo_wr_n), 1);
    chk("R1 data after reset", int'(fifo_data), 0);

    win = 1'b1; sw = slot;
    step(2);

    // R2 R3: every channel, rising then falling
    for (int c = 0; c < NCH; c++) begin
      for (int e = 0; e < 2; e++) begin
        got_n = 0; se = slot;
        ch[c] = ~ch[c];
        step(8);
        chk("R2 write count", got_n, 1);
        chk_write("R3", 0, 1 << c, se - sw, DLY);
      end
    end

    // R4: every nonzero set of coincident channels
    for (int m = 1; m < (1 << NCH); m++) begin
      got_n = 0; se = slot;
      ch = ch ^ NCH'(m);
      step(8);
      chk("R4 write count", got_n, 1);
      chk_write("R4", 0, m, se - sw, DLY);
    end

    // R5 R6: second channel at offsets 1..5 edges
    for (int g = 1; g <= 5; g++) begin
      got_n = 0; se = slot;
      ch[0] = ~ch[0];
      step(g);
      ch[1] = ~ch[1];
      step(9);
      if (g <= DLY) begin
        chk("R5 write count", got_n, 1);
        chk_write("R5", 0, 3, se - sw, DLY + g);
      end else begin
        chk("R6 write count", got_n, 2);
        chk_write("R6 first", 0, 1, se - sw, DLY);
        chk_write("R6 second", 1, 2, se + g - sw, DLY);
      end
    end

    // R7: window closed ignores changes
    win = 1'b0;
    step(2);
    got_n = 0;
    ch = ch ^ 4'hF;
    step(8);
    chk("R7 closed window writes", got_n, 0);
    chk("R7 closed window wr_n", int'(fifo_wr_n), 1);

    // R7: window falls during a pulse, write completes
    win = 1'b1; sw = slot;
    step(2);
    got_n = 0; se = slot;
    ch[0] = ~ch[0];
    step(1);
    win = 1'b0;
    step(8);
    chk("R7 window falls count", got_n, 1);
    chk_write("R7 window falls", 0, 1, se - sw, DLY);

    // R3: restart on reopen and wrap past 2^CW
    win = 1'b1; sw = slot;
    step(300);
    got_n = 0; se = slot;
    ch[3] = ~ch[3];
    step(8);
    chk("R3 wrap count", got_n, 1);
    chk_write("R3 wrap", 0, 8, se - sw, DLY);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PER * 200000);
    checks++; errs++;
    $display("FAIL watchdog R2 got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule